// File: doc/BRIEF.md
# Predicated Commit Unit

This block keeps a bank of one-bit condition flags and uses them to decide whether a retiring instruction may change a small general register file. A compare port records a condition outcome and its complement into two flags in a single cycle. A retire port names one flag, a destination register and a result. The destination is updated only when the named flag is set, so the instructions of both arms of an if/else can be merged into one branch-free stream, with each arm guarded by one of the two complementary flags.

Two conditional-move forms go through the same gate. One copies a source register when a tested register holds zero. The other copies it when the tested register is non-zero. Flag 0 always reads as one, so unconditional instructions can name it. The general register file sits inside the block and has two combinational read ports. A separate combinational port reads any flag.

Top module: `pred_commit_unit`

## Requirements
- R1: After reset, flag 0 reads 1, flags 1..63 read 0, and all 16 general registers read 0.
- R2: A compare with `cmp_valid` high writes `cmp_cond` to flag `cmp_true_idx` and its inverse to flag `cmp_false_idx`, both visible on the flag read port after that clock edge.
- R3: When a compare names the same flag for both outputs, that flag takes the value of `cmp_cond`.
- R4: Flag 0 always reads 1 and is not changed by any compare.
- R5: A retire with `ret_op` = 2'b00 writes `ret_result` to register `ret_dst` only if flag `ret_pred` is 1. Otherwise the destination keeps its old value.
- R6: A retire with `ret_op` = 2'b01 copies register `ret_src` into `ret_dst` only when register `ret_test` equals zero and flag `ret_pred` is 1.
- R7: A retire with `ret_op` = 2'b10 copies register `ret_src` into `ret_dst` only when register `ret_test` is non-zero and flag `ret_pred` is 1.
- R8: A retire with `ret_op` = 2'b11 never changes any register.
- R9: A retire in the same cycle as a compare to its flag uses the flag value from before that compare. The new value applies to retires in later cycles.
- R10: Both general register read ports return the addressed register combinationally, including a value written at the previous clock edge.
- R11: With `ret_valid` low, no register changes, whatever the other retire inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare write enable |
| cmp_cond | input | 1 | Compare outcome |
| cmp_true_idx | input | 6 | Flag that receives the outcome |
| cmp_false_idx | input | 6 | Flag that receives the inverse |
| ret_valid | input | 1 | Retiring instruction present |
| ret_op | input | 2 | 00 write result, 01 move if test zero, 10 move if test non-zero, 11 no write |
| ret_pred | input | 6 | Guarding flag index |
| ret_dst | input | 4 | Destination register |
| ret_src | input | 4 | Move source register |
| ret_test | input | 4 | Move test register |
| ret_result | input | 32 | Result value for op 00 |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 32 | Read port 1 data |
| pred_rd_idx | input | 6 | Flag read index |
| pred_rd_val | output | 1 | Flag read value |

## Verification
The bench sends a compare and a retire to the same flag in one cycle. A design with a bypass would then commit a write that should be suppressed. It names one flag as both compare targets, where getting the write order wrong leaves the inverted value. It also aims compares at flag 0, where a design that fails to protect the flag would lose unconditional execution. Each conditional move is tried against a zero and a non-zero test register. Each retire form is also issued with a false flag, with op 11 and with `ret_valid` low. A design that decodes the gate loosely would change a register in one of these cases.

// File: rtl/pred_commit_unit.sv
module pred_commit_unit #(
  parameter int NUM_PRED = 64,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int PW = $clog2(NUM_PRED),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_cond,
  input  logic [PW-1:0]     cmp_true_idx,
  input  logic [PW-1:0]     cmp_false_idx,
  input  logic              ret_valid,
  input  logic [1:0]        ret_op,
  input  logic [PW-1:0]     ret_pred,
  input  logic [RW-1:0]     ret_dst,
  input  logic [RW-1:0]     ret_src,
  input  logic [RW-1:0]     ret_test,
  input  logic [DATA_W-1:0] ret_result,
  input  logic [RW-1:0]     rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [RW-1:0]     rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic [PW-1:0]     pred_rd_idx,
  output logic              pred_rd_val
);

  logic [NUM_PRED-1:0] pred_q;
  logic [DATA_W-1:0]   gpr_q [NUM_REGS];

  logic              test_zero;
  logic              op_ok;
  logic              commit;
  logic [DATA_W-1:0] wr_val;

  assign test_zero = (gpr_q[ret_test] == '0);
  assign op_ok = (ret_op == 2'b00) ||
                 (ret_op == 2'b01 && test_zero) ||
                 (ret_op == 2'b10 && !test_zero);
  assign commit = ret_valid && pred_q[ret_pred] && op_ok;
  assign wr_val = (ret_op == 2'b00) ? ret_result : gpr_q[ret_src];

  assign rd0_data    = gpr_q[rd0_idx];
  assign rd1_data    = gpr_q[rd1_idx];
  assign pred_rd_val = pred_q[pred_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= {{(NUM_PRED-1){1'b0}}, 1'b1};
    end else if (cmp_valid) begin
      for (int i = 1; i < NUM_PRED; i++) begin
        if (cmp_false_idx == PW'(i)) pred_q[i] <= ~cmp_cond;
        if (cmp_true_idx == PW'(i))  pred_q[i] <= cmp_cond;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) gpr_q[r] <= '0;
    end else if (commit) begin
      gpr_q[ret_dst] <= wr_val;
    end
  end

  assert_cmp_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_true_idx != '0) |=> pred_q[$past(cmp_true_idx)] == $past(cmp_cond));

  assert_cmp_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_false_idx != '0 && cmp_false_idx != cmp_true_idx)
      |=> pred_q[$past(cmp_false_idx)] == !$past(cmp_cond));

  assert_pred_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> pred_q[0]);

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !pred_q[ret_pred]) |=> gpr_q[$past(ret_dst)] == $past(gpr_q[ret_dst]));

  assert_movz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_op == 2'b01 && pred_q[ret_pred] && gpr_q[ret_test] == '0)
      |=> gpr_q[$past(ret_dst)] == $past(gpr_q[ret_src]));

  assert_movn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_op == 2'b10 && pred_q[ret_pred] && gpr_q[ret_test] != '0)
      |=> gpr_q[$past(ret_dst)] == $past(gpr_q[ret_src]));

  assert_op_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_op == 2'b11) |=> gpr_q[$past(ret_dst)] == $past(gpr_q[ret_dst]));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> gpr_q[$past(ret_dst)] == $past(gpr_q[ret_dst]));

endmodule

// File: tb/tb_pred_commit_unit.sv
module tb_pred_commit_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0, cmp_cond = 1'b0;
  logic [5:0] cmp_true_idx = '0, cmp_false_idx = '0;
  logic ret_valid = 1'b0;
  logic [1:0] ret_op = '0;
  logic [5:0] ret_pred = '0;
  logic [3:0] ret_dst = '0, ret_src = '0, ret_test = '0;
  logic [31:0] ret_result = '0;
  logic [3:0] rd0_idx = '0, rd1_idx = '0;
  logic [31:0] rd0_data, rd1_data;
  logic [5:0] pred_rd_idx = '0;
  logic pred_rd_val;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pred_commit_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
    .cmp_true_idx(cmp_true_idx), .cmp_false_idx(cmp_false_idx),
    .ret_valid(ret_valid), .ret_op(ret_op), .ret_pred(ret_pred),
    .ret_dst(ret_dst), .ret_src(ret_src), .ret_test(ret_test),
    .ret_result(ret_result),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .pred_rd_idx(pred_rd_idx), .pred_rd_val(pred_rd_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmp_valid = 1'b0;
    ret_valid = 1'b0;
  endtask

  task automatic reg_is(input string req, input logic [3:0] r, input logic [31:0] exp);
    rd0_idx = r;
    #1;
    chk(req, rd0_data, exp);
  endtask

  task automatic pred_is(input string req, input logic [5:0] p, input logic exp);
    pred_rd_idx = p;
    #1;
    chk(req, {31'b0, pred_rd_val}, {31'b0, exp});
  endtask

  task automatic do_cmp(input logic c, input logic [5:0] t, input logic [5:0] f);
    cmp_valid = 1'b1; cmp_cond = c; cmp_true_idx = t; cmp_false_idx = f;
    tick();
  endtask

  task automatic do_ret(input logic [1:0] op, input logic [5:0] p, input logic [3:0] d,
                        input logic [3:0] s, input logic [3:0] tst, input logic [31:0] v);
    ret_valid = 1'b1; ret_op = op; ret_pred = p; ret_dst = d;
    ret_src = s; ret_test = tst; ret_result = v;
    tick();
  endtask

  task automatic t_reset();
    pred_is("R1", 6'd0, 1'b1);
    pred_is("R1", 6'd5, 1'b0);
    pred_is("R1", 6'd63, 1'b0);
    reg_is("R1", 4'd0, 32'h0);
    reg_is("R1", 4'd15, 32'h0);
  endtask

  task automatic t_load();
    do_ret(2'b00, 6'd0, 4'd1, 4'd0, 4'd0, 32'h11);
    do_ret(2'b00, 6'd0, 4'd2, 4'd0, 4'd0, 32'h22);
    do_ret(2'b00, 6'd0, 4'd4, 4'd0, 4'd0, 32'h5);
    reg_is("R5", 4'd1, 32'h11);
  endtask

  task automatic t_read_ports();
    rd0_idx = 4'd1; rd1_idx = 4'd2;
    #1;
    chk("R10", rd0_data, 32'h11);
    chk("R10", rd1_data, 32'h22);
  endtask

  task automatic t_compare();
    do_cmp(1'b1, 6'd3, 6'd4);
    pred_is("R2", 6'd3, 1'b1);
    pred_is("R2", 6'd4, 1'b0);
    do_cmp(1'b0, 6'd7, 6'd8);
    pred_is("R2", 6'd7, 1'b0);
    pred_is("R2", 6'd8, 1'b1);
  endtask

  task automatic t_same_idx();
    do_cmp(1'b0, 6'd9, 6'd9);
    pred_is("R3", 6'd9, 1'b0);
    do_cmp(1'b1, 6'd9, 6'd9);
    pred_is("R3", 6'd9, 1'b1);
  endtask

  task automatic t_pred0();
    do_cmp(1'b0, 6'd0, 6'd10);
    pred_is("R4", 6'd0, 1'b1);
    pred_is("R4", 6'd10, 1'b1);
    do_cmp(1'b1, 6'd11, 6'd0);
    pred_is("R4", 6'd0, 1'b1);
  endtask

  task automatic t_gated();
    do_ret(2'b00, 6'd4, 4'd5, 4'd0, 4'd0, 32'hdead);
    reg_is("R5", 4'd5, 32'h0);
    do_ret(2'b00, 6'd3, 4'd5, 4'd0, 4'd0, 32'hbeef);
    reg_is("R5", 4'd5, 32'hbeef);
  endtask

  task automatic t_movz();
    do_ret(2'b01, 6'd0, 4'd6, 4'd2, 4'd3, 32'hffff);
    reg_is("R6", 4'd6, 32'h22);
    do_ret(2'b01, 6'd0, 4'd7, 4'd2, 4'd4, 32'hffff);
    reg_is("R6", 4'd7, 32'h0);
    do_ret(2'b01, 6'd4, 4'd8, 4'd2, 4'd3, 32'hffff);
    reg_is("R6", 4'd8, 32'h0);
  endtask

  task automatic t_movn();
    do_ret(2'b10, 6'd0, 4'd9, 4'd1, 4'd4, 32'hffff);
    reg_is("R7", 4'd9, 32'h11);
    do_ret(2'b10, 6'd0, 4'd10, 4'd1, 4'd3, 32'hffff);
    reg_is("R7", 4'd10, 32'h0);
  endtask

  task automatic t_op_none();
    do_ret(2'b11, 6'd0, 4'd1, 4'd2, 4'd3, 32'h99);
    reg_is("R8", 4'd1, 32'h11);
  endtask

  task automatic t_no_bypass();
    cmp_valid = 1'b1; cmp_cond = 1'b1; cmp_true_idx = 6'd12; cmp_false_idx = 6'd13;
    ret_valid = 1'b1; ret_op = 2'b00; ret_pred = 6'd12; ret_dst = 4'd11; ret_result = 32'h77;
    tick();
    reg_is("R9", 4'd11, 32'h0);
    do_ret(2'b00, 6'd12, 4'd11, 4'd0, 4'd0, 32'h77);
    reg_is("R9", 4'd11, 32'h77);
  endtask

  task automatic t_idle();
    ret_valid = 1'b0; ret_op = 2'b00; ret_pred = 6'd0; ret_dst = 4'd12; ret_result = 32'h55;
    tick();
    reg_is("R11", 4'd12, 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_read_ports();
    t_compare();
    t_same_idx();
    t_pred0();
    t_gated();
    t_movz();
    t_movn();
    t_op_none();
    t_no_bypass();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule